// File: doc/BRIEF.md
# Packed Single-Precision to Int32 Truncating Converter

This block turns a 256-bit vector of eight IEEE-754 single-precision lanes into eight signed 32-bit integers, always rounding toward zero regardless of any rounding-mode setting elsewhere in the core. Each lane is converted on its own. Lane i reads source bits [32i+31:32i] and writes the same bit range of the result. A two-bit width mode picks one of three behaviours. The two half-width modes convert only lanes 0 to 3. One of them keeps the upper 128 bits of the previous destination value, and the other clears them. The full-width mode converts all eight lanes.

Any lane whose value cannot be represented is saturated to the indefinite value 0x80000000 and raises an invalid flag. This covers finite values out of range as well as NaN and infinity. A lane that drops a nonzero fraction raises an inexact flag. The flags are collected only over the lanes the mode makes active. When invalid is unmasked, the result is suppressed so that the surrounding pipeline can take the exception. The two vector-encoded modes also check a 4-bit reserved operand field, which must read all ones. Any other value gives an undefined-opcode indication and suppresses the write. The block has one register stage: the result arrives one cycle after valid_i.

Top module: `pk_trunc_cvt`

## Requirements
- R1: Each active lane i converts src_i[32i+31:32i] into dst_o[32i+31:32i], rounding toward zero (for example, -1.7 gives -1 and 2.9 gives 2).
- R2: A finite lane whose truncated value lies outside [-2^31, 2^31-1] gives 0x80000000 and raises invalid_o.
- R3: NaN and infinity of either sign give 0x80000000 and raise invalid_o.
- R4: A lane exactly equal to -2^31 (0xCF000000) gives 0x80000000 and does not raise invalid_o.
- R5: inexact_o is raised when an active lane drops a nonzero fraction. Zeros and denormals of either sign give 0, and a nonzero denormal also raises inexact_o.
- R6: mode_i=2'b00 (legacy half) converts lanes 0 to 3, passes old_dst_i[255:128] unchanged to dst_o[255:128], and ignores rsv_i.
- R7: mode_i=2'b01 (short vector) converts lanes 0 to 3 and forces dst_o[255:128] to zero.
- R8: mode_i=2'b10 or 2'b11 (full width) converts all eight lanes.
- R9: In any mode other than 2'b00, rsv_i other than 4'b1111 raises ud_o and holds wr_o, dst_o, invalid_o and inexact_o at 0.
- R10: invalid_o and inexact_o are the OR over the active lanes only. Lanes 4 to 7 have no effect on them in the half-width modes.
- R11: With inv_mask_i=0 and some active lane invalid, wr_o=0 and dst_o=0 while invalid_o is still raised. With inv_mask_i=1, wr_o=1 and the saturated result is delivered.
- R12: Outputs appear exactly one cycle after valid_i. All outputs are zero while valid_o is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands are valid this cycle |
| mode_i | input | 2 | Width mode: 00 legacy half, 01 short vector, 1x full width |
| rsv_i | input | 4 | Reserved operand field, must be 4'b1111 in vector modes |
| inv_mask_i | input | 1 | Invalid response is masked (deliver saturated result) |
| src_i | input | 256 | Eight packed single-precision source lanes |
| old_dst_i | input | 256 | Previous destination value, upper half reused in legacy mode |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| wr_o | output | 1 | Result may be written to the destination |
| ud_o | output | 1 | Undefined-opcode indication from a bad reserved field |
| invalid_o | output | 1 | Invalid flag over active lanes |
| inexact_o | output | 1 | Inexact flag over active lanes |
| dst_o | output | 256 | Packed signed 32-bit results |

## Verification
The converter is driven with exact integers, values that carry fractions of both signs, zeros and denormals, the two boundary values next to 2^31, both infinities, NaN, and magnitudes far above range. Each group separates a different path: plain truncation, the inexact rule, the lone exact -2^31 case, and saturation. The same lane patterns are run in every width mode. Non-numeric values are placed only in the upper lanes, which shows whether the flags are gated to the active half and whether the old or the zeroed upper half reaches the output. Reserved-field and mask variations are then crossed with those modes, and randomized vectors are compared against a real-arithmetic model every cycle.

// File: rtl/ftoi_pkg.sv
`timescale 1ns/1ps
package ftoi_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_SHORT  = 2'b01,
    MODE_WIDE   = 2'b10,
    MODE_WIDE_X = 2'b11
  } cvt_mode_e;

  localparam logic [31:0] INT_INDEF   = 32'h8000_0000;
  localparam logic [31:0] F32_NEG_2P31 = 32'hCF00_0000;
  localparam int unsigned F32_BIAS    = 127;
  localparam int unsigned F32_MAN_W   = 23;
endpackage

// File: rtl/ftoi_lane.sv
`timescale 1ns/1ps
module ftoi_lane
  import ftoi_pkg::*;
(
  input  logic [31:0] f_i,
  output logic [31:0] int_o,
  output logic        inv_o,
  output logic        inx_o
);
  localparam int unsigned TMP_W = 32 + F32_MAN_W;   // integer part + fraction

  logic             sgn;
  logic [7:0]       ex;
  logic [22:0]      man;
  logic [TMP_W-1:0] tmp;
  logic [31:0]      mag;

  assign sgn = f_i[31];
  assign ex  = f_i[30:23];
  assign man = f_i[22:0];

  always_comb begin
    int_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    tmp   = '0;
    mag   = '0;
    if (ex == 8'hFF) begin
      int_o = INT_INDEF;
      inv_o = 1'b1;
    end else if (ex == 8'h00) begin
      inx_o = |man;
    end else if (ex < 8'(F32_BIAS)) begin
      inx_o = 1'b1;                       // 0 < |x| < 1
    end else if (ex >= 8'(F32_BIAS + 31)) begin
      int_o = INT_INDEF;
      inv_o = (f_i != F32_NEG_2P31);
    end else begin
      tmp   = {31'b0, 1'b1, man} << (ex - 8'(F32_BIAS));
      mag   = tmp[TMP_W-1:F32_MAN_W];
      inx_o = |tmp[F32_MAN_W-1:0];
      int_o = sgn ? (~mag + 32'd1) : mag;
    end
  end
endmodule

// File: rtl/ftoi_ctrl.sv
`timescale 1ns/1ps
module ftoi_ctrl
  import ftoi_pkg::*;
#(
  parameter int unsigned NUM_LANES = 8,
  parameter int unsigned RSV_W     = 4
) (
  input  logic                 valid_i,
  input  logic [1:0]           mode_i,
  input  logic [RSV_W-1:0]     rsv_i,
  input  logic                 any_inv_i,
  input  logic                 inv_mask_i,
  output logic [NUM_LANES-1:0] lane_en_o,
  output logic                 zero_upper_o,
  output logic                 ud_o,
  output logic                 wr_o
);
  localparam int unsigned HALF = NUM_LANES / 2;

  cvt_mode_e mode;
  logic      wide;

  assign mode = cvt_mode_e'(mode_i);
  assign wide = (mode == MODE_WIDE) || (mode == MODE_WIDE_X);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_en
    if (i < HALF) begin : g_lo
      assign lane_en_o[i] = 1'b1;
    end else begin : g_hi
      assign lane_en_o[i] = wide;
    end
  end

  assign zero_upper_o = (mode == MODE_SHORT);
  assign ud_o = valid_i && (mode != MODE_LEGACY) && (rsv_i != '1);
  assign wr_o = valid_i && !ud_o && !(any_inv_i && !inv_mask_i);
endmodule

// File: rtl/pk_trunc_cvt.sv
`timescale 1ns/1ps
module pk_trunc_cvt
  import ftoi_pkg::*;
#(
  parameter int unsigned NUM_LANES = 8,
  parameter int unsigned RSV_W     = 4,
  localparam int unsigned LANE_W   = 32,
  localparam int unsigned VEC_W    = NUM_LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic [RSV_W-1:0] rsv_i,
  input  logic             inv_mask_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] old_dst_i,
  output logic             valid_o,
  output logic             wr_o,
  output logic             ud_o,
  output logic             invalid_o,
  output logic             inexact_o,
  output logic [VEC_W-1:0] dst_o
);
  logic [LANE_W-1:0]    lane_int [NUM_LANES];
  logic [NUM_LANES-1:0] lane_inv, lane_inx, lane_en;
  logic [VEC_W-1:0]     res;
  logic                 any_inv, any_inx, zero_upper, ud, wr;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    ftoi_lane u_lane (
      .f_i   (src_i[i*LANE_W +: LANE_W]),
      .int_o (lane_int[i]),
      .inv_o (lane_inv[i]),
      .inx_o (lane_inx[i])
    );
    assign res[i*LANE_W +: LANE_W] = lane_en[i] ? lane_int[i] :
                                     zero_upper ? '0 : old_dst_i[i*LANE_W +: LANE_W];
  end

  assign any_inv = |(lane_inv & lane_en);
  assign any_inx = |(lane_inx & lane_en);

  ftoi_ctrl #(.NUM_LANES(NUM_LANES), .RSV_W(RSV_W)) u_ctrl (
    .valid_i      (valid_i),
    .mode_i       (mode_i),
    .rsv_i        (rsv_i),
    .any_inv_i    (any_inv),
    .inv_mask_i   (inv_mask_i),
    .lane_en_o    (lane_en),
    .zero_upper_o (zero_upper),
    .ud_o         (ud),
    .wr_o         (wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_o      <= 1'b0;
      ud_o      <= 1'b0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      dst_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      wr_o      <= wr;
      ud_o      <= ud;
      invalid_o <= valid_i && !ud && any_inv;
      inexact_o <= valid_i && !ud && any_inx;
      dst_o     <= wr ? res : '0;
    end
  end
endmodule

// File: rtl/pk_trunc_cvt_chk.sv
`timescale 1ns/1ps
module pk_trunc_cvt_chk
  import ftoi_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned RSV_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic [RSV_W-1:0] rsv_i,
  input logic             inv_mask_i,
  input logic [VEC_W-1:0] old_dst_i,
  input logic             valid_o,
  input logic             wr_o,
  input logic             ud_o,
  input logic             invalid_o,
  input logic             inexact_o,
  input logic [VEC_W-1:0] dst_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  assert_latency_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(wr_o || ud_o || invalid_o || inexact_o) && (dst_o == '0));
  assert_ud_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_o |-> !wr_o && !invalid_o && !inexact_o && (dst_o == '0));
  assert_bad_rsv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != MODE_LEGACY && rsv_i != '1) |=> ud_o);
  assert_legacy_no_ud_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_LEGACY) |=> !ud_o);
  assert_legacy_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_LEGACY) |=>
      (!wr_o || dst_o[VEC_W-1:HALF_W] == $past(old_dst_i[VEC_W-1:HALF_W])));
  assert_short_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_SHORT) |=> (dst_o[VEC_W-1:HALF_W] == '0));
  assert_unmasked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !inv_mask_i) |=> !(invalid_o && wr_o));
endmodule

bind pk_trunc_cvt pk_trunc_cvt_chk #(.VEC_W(VEC_W), .RSV_W(RSV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .rsv_i(rsv_i), .inv_mask_i(inv_mask_i), .old_dst_i(old_dst_i),
  .valid_o(valid_o), .wr_o(wr_o), .ud_o(ud_o), .invalid_o(invalid_o),
  .inexact_o(inexact_o), .dst_o(dst_o)
);

// File: tb/sim_pk_trunc_cvt.sv
`timescale 1ns/1ps
module sim_pk_trunc_cvt;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic [3:0]   rsv_i = '0;
  logic         inv_mask_i = 1'b1;
  logic [255:0] src_i = '0;
  logic [255:0] old_dst_i = '0;
  logic         valid_o, wr_o, ud_o, invalid_o, inexact_o;
  logic [255:0] dst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pk_trunc_cvt u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .rsv_i(rsv_i), .inv_mask_i(inv_mask_i), .src_i(src_i), .old_dst_i(old_dst_i),
    .valid_o(valid_o), .wr_o(wr_o), .ud_o(ud_o), .invalid_o(invalid_o),
    .inexact_o(inexact_o), .dst_o(dst_o)
  );

  // returns {invalid, inexact, value}
  function automatic logic [33:0] ref_lane(input logic [31:0] f);
    int  e;
    real v;
    int  t;
    e = int'(f[30:23]);
    if (e == 255) return {2'b10, 32'h8000_0000};
    if (e == 0) v = real'(f[22:0]) * (2.0 ** (-149));
    else        v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    if (f[31]) v = -v;
    if (v >= 2147483648.0 || v < -2147483648.0) return {2'b10, 32'h8000_0000};
    t = $rtoi(v);
    return {1'b0, ($itor(t) != v), 32'(t)};
  endfunction

  task automatic step(input logic v, input logic [1:0] m, input logic [3:0] r,
                      input logic msk, input logic [255:0] s, input logic [255:0] od,
                      input string tag);
    logic [255:0] e_dst, asm;
    logic e_inv, e_inx, e_ud, e_wr;
    logic [33:0] l;
    valid_i = v; mode_i = m; rsv_i = r; inv_mask_i = msk; src_i = s; old_dst_i = od;
    e_inv = 0; e_inx = 0; asm = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < 4 || m[1]) begin
        l = ref_lane(s[i*32 +: 32]);
        asm[i*32 +: 32] = l[31:0];
        e_inv |= l[33];
        e_inx |= l[32];
      end else if (m == 2'b00) begin
        asm[i*32 +: 32] = od[i*32 +: 32];
      end
    end
    e_ud  = v && (m != 2'b00) && (r != 4'hF);
    e_wr  = v && !e_ud && !(e_inv && !msk);
    e_dst = e_wr ? asm : '0;
    e_inv = v && !e_ud && e_inv;
    e_inx = v && !e_ud && e_inx;
    @(negedge clk);
    n_run++;
    if ({valid_o, wr_o, ud_o, invalid_o, inexact_o} != {v, e_wr, e_ud, e_inv, e_inx} ||
        dst_o !== e_dst) begin
      n_fail++;
      $display("FAIL %s: act vld/wr/ud/inv/inx=%b dst=%h exp=%b dst=%h", tag,
               {valid_o, wr_o, ud_o, invalid_o, inexact_o}, dst_o,
               {v, e_wr, e_ud, e_inv, e_inx}, e_dst);
    end
  endtask

  function automatic logic [255:0] pack8(input logic [31:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  function automatic logic [31:0] rnd_f32();
    logic [7:0] e;
    case ($urandom_range(0, 7))
      0: e = 8'hFF;
      1: e = 8'h00;
      2: e = 8'd158;
      default: e = 8'($urandom_range(110, 165));
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  localparam logic [255:0] OLD = {8{32'hA5A5_5A5A}};
  localparam logic [255:0] VEC_A = {32'hC0400000, 32'h3F000000, 32'h80000000, 32'h00000001,
                                    32'h4039999A, 32'hBFD9999A, 32'h3F800000, 32'h4EFFFFFF};
  localparam logic [255:0] VEC_EXACT = {32'h3F800000, 32'hC0400000, 32'h4EFFFFFF, 32'h00000000,
                                        32'hCF000000, 32'h3F800000, 32'hC0400000, 32'h4E800000};

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if ({valid_o, wr_o, ud_o, invalid_o, inexact_o} != 5'b0 || dst_o != '0) begin
      n_fail++;
      $display("FAIL R12 reset: act %b %h exp 0 0", {valid_o, wr_o, ud_o, invalid_o, inexact_o}, dst_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 R5 R8: mixed fractions, zeros, denormal, exact
    step(1, 2'b10, 4'hF, 1, VEC_A, OLD, "R1/R5/R8 wide mixed");
    step(1, 2'b10, 4'hF, 1, VEC_EXACT, OLD, "R4/R8 exact values");
    // R6: legacy keeps old upper, reserved field ignored
    step(1, 2'b00, 4'h3, 1, VEC_A, OLD, "R6 legacy");
    // R7: short clears upper
    step(1, 2'b01, 4'hF, 1, VEC_A, OLD, "R7 short");
    step(1, 2'b11, 4'hF, 1, VEC_EXACT, OLD, "R8 mode 11");
    // R2 R3: out-of-range and non-numeric, masked
    step(1, 2'b10, 4'hF, 1, pack8(32'h4F000000, 32'h501502F9, 32'h7FC00000, 32'h7F800000,
                                  32'hFF800000, 32'hCF000001, 32'h3F800000, 32'hCF000000),
         OLD, "R2/R3 saturate");
    // R10: bad lanes only in upper half, half modes
    step(1, 2'b01, 4'hF, 1, pack8(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
                                  32'h7FC00000, 32'h3F000000, 32'h7F800000, 32'h4F000000),
         OLD, "R10 short upper ignored");
    step(1, 2'b00, 4'hF, 0, pack8(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
                                  32'h7FC00000, 32'h3F000000, 32'h7F800000, 32'h4F000000),
         OLD, "R10 legacy upper ignored");
    // R11: unmasked invalid suppresses write
    step(1, 2'b10, 4'hF, 0, pack8(32'h7F800000, 32'h3F800000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0),
         OLD, "R11 unmasked");
    // R9: bad reserved field in vector modes
    step(1, 2'b01, 4'hE, 1, VEC_A, OLD, "R9 short bad rsv");
    step(1, 2'b10, 4'h0, 1, VEC_A, OLD, "R9 wide bad rsv");
    // R12: idle cycle
    step(0, 2'b10, 4'hF, 1, VEC_A, OLD, "R12 idle");
    step(1, 2'b10, 4'hF, 1, VEC_A, OLD, "R12 resume");
    for (int k = 0; k < 400; k++) begin
      logic [255:0] s, od;
      for (int i = 0; i < 8; i++) begin
        s[i*32 +: 32]  = rnd_f32();
        od[i*32 +: 32] = $urandom;
      end
      step(1'($urandom_range(0, 7) != 0), 2'($urandom), ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF,
           1'($urandom_range(0, 3) != 0), s, od, "R1-random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: act hung exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule